// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block turns one bus-cycle request into the strobe waveforms an 8-bit NAND flash device expects. A request names one of four cycle kinds: command, address, write data or read data. It also carries the byte to send. Once the block accepts the request, it runs three phases, one after the other: setup, pulse and hold. Each phase length is programmable. For command and address cycles the block raises the latch line that matches the kind. For writes it drives the data bus and pulses the write strobe. For reads it pulses the read strobe and latches the bus on the last pulse clock.

After the hold phase the block waits before the device ready line may be trusted. This wait is counted in pairs of clocks. When the wait ends, the block signals completion for one clock.

All phase lengths come from a 32-bit timing word. The word has one half for write-type cycles and one half for read cycles. The block copies the relevant half when it accepts a request, so software may rewrite the word at any time without disturbing the cycle in progress. Requests are taken one at a time, only while the block is idle.

Top module: `nandStrobeGen`

## Requirements
- R1: The write-type half of the timing word is bits [31:16] and is used for command, address and write-data cycles. Within it, [19:16] is setup, [23:20] is hold, [27:24] is pulse and [31:28] is the ready wait. The read half is bits [15:0], with the same layout: [3:0] setup, [7:4] hold, [11:8] pulse, [15:12] ready wait. Read cycles use only the read half.
- R2: A setup, pulse or hold field of value n lasts exactly n+1 clocks. An all-zero timing word gives one-clock phases and no ready wait.
- R3: After the hold phase, the ready wait lasts 2×n clocks, where n is the selected wait field. During the wait all strobes are inactive and busy stays high. A value of 0 skips the wait.
- R4: reqKind encodes 0 = command, 1 = address, 2 = write data, 3 = read data. nandCle is high through setup, pulse and hold of a command cycle only. nandAle is high through those phases of an address cycle only. Both are low at all other times.
- R5: For cycles of kind 0, 1 and 2, nandDqOe is high and nandDq carries the request byte from the first setup clock to the last hold clock. nandWeN is low only during the pulse phase, and nandReN stays high.
- R6: For a read cycle, nandReN is low only during the pulse phase, and nandDqOe and nandWeN stay inactive. nandDqIn is sampled at the end of the last pulse clock and appears on rdData from the first hold clock. rdData keeps that value until the next read completes its pulse.
- R7: reqAccept equals reqValid while busy is low and is 0 while busy is high. A request offered while busy is ignored. busy rises on the clock after acceptance and falls when the ready wait ends, or when the hold ends if there is no wait.
- R8: done is a single-clock pulse in the first idle clock after a cycle finishes.
- R9: The timing word is sampled only when a request is accepted. Changing it during a cycle does not alter that cycle.
- R10: While reset (rstN low) is asserted and right after it: busy, done, nandCle, nandAle and nandDqOe are low, nandWeN and nandReN are high, and rdData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A cycle request is offered |
| reqKind | input | 2 | Cycle kind: 0 command, 1 address, 2 write data, 3 read data |
| reqData | input | 8 | Byte sent in command, address and write-data cycles |
| timingWord | input | 32 | Phase timing, write half [31:16], read half [15:0] |
| reqAccept | output | 1 | Request taken this clock |
| busy | output | 1 | A cycle or its ready wait is in progress |
| done | output | 1 | One-clock completion pulse |
| rdData | output | 8 | Byte captured by the most recent read |
| nandDqIn | input | 8 | Data bus value from the device |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDq | output | 8 | Data bus value toward the device |
| nandDqOe | output | 1 | Data bus output enable |

## Verification
Every request in the test is compared clock by clock against an expected trace built from the timing fields. The patterns are chosen to tell the two halves of the timing word apart, each half is filled with different values. One request uses all-zero timing. Others use maximal pulse and wait values, and one uses a wait of zero; these show off-by-one errors in the phase counts and the doubling in the ready wait.

During read requests, the bench drives the wrong byte on the bus on every clock except the last pulse clock. This exposes a capture taken on the wrong clock. Some requests hold reqValid high for their whole duration with a different kind, and rewrite the timing word after acceptance. These separate a correct design from one that takes a request while busy, or one that re-reads the timing word during a cycle.

// File: rtl/nandStrobePkg.sv
package nandStrobePkg;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_WDATA = 2'd2,
    KIND_RDATA = 2'd3
  } cycKind_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_WAIT
  } phase_t;

  // Strobe bundle from the sequencer to the pin datapath
  typedef struct packed {
    logic loadData;
    logic drive;
    logic weLow;
    logic reLow;
    logic capture;
    logic cleOn;
    logic aleOn;
  } strobe_t;

endpackage

// File: rtl/nandStrobeCtl.sv
module nandStrobeCtl
  import nandStrobePkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [1:0]           reqKind,
  input  logic [8*FIELD_W-1:0] timingWord,
  output logic                 reqAccept,
  output logic                 busy,
  output logic                 done,
  output strobe_t              strb
);

  localparam int HALF_W = 4 * FIELD_W;
  localparam int CNT_W  = FIELD_W + 1;

  // Fields inside one half of the timing word
  localparam int SETUP_LSB = 0;
  localparam int HOLD_LSB  = FIELD_W;
  localparam int PULSE_LSB = 2 * FIELD_W;
  localparam int WAIT_LSB  = 3 * FIELD_W;

  phase_t             phaseQ, phaseD;
  cycKind_t           kindQ;
  logic [CNT_W-1:0]   cntQ, cntD;
  logic [FIELD_W-1:0] pulseQ, holdQ, waitQ;
  logic               doneQ, goIdle;

  logic [HALF_W-1:0]  halfSel;
  logic               cntZero;
  logic               isRead;
  logic               active;

  assign busy      = (phaseQ != PH_IDLE);
  assign reqAccept = reqValid && !busy;
  assign done      = doneQ;
  assign cntZero   = (cntQ == '0);
  assign isRead    = (kindQ == KIND_RDATA);

  assign halfSel = (cycKind_t'(reqKind) == KIND_RDATA) ? timingWord[HALF_W-1:0]
                                                       : timingWord[2*HALF_W-1:HALF_W];

  always_comb begin
    phaseD = phaseQ;
    cntD   = cntQ;
    goIdle = 1'b0;
    unique case (phaseQ)
      PH_IDLE: begin
        if (reqAccept) begin
          phaseD = PH_SETUP;
          cntD   = CNT_W'(halfSel[SETUP_LSB +: FIELD_W]);
        end
      end
      PH_SETUP: begin
        if (cntZero) begin
          phaseD = PH_PULSE;
          cntD   = CNT_W'(pulseQ);
        end else begin
          cntD = cntQ - CNT_W'(1);
        end
      end
      PH_PULSE: begin
        if (cntZero) begin
          phaseD = PH_HOLD;
          cntD   = CNT_W'(holdQ);
        end else begin
          cntD = cntQ - CNT_W'(1);
        end
      end
      PH_HOLD: begin
        if (cntZero) begin
          if (waitQ != '0) begin
            phaseD = PH_WAIT;
            cntD   = {waitQ, 1'b0} - CNT_W'(1);
          end else begin
            phaseD = PH_IDLE;
            goIdle = 1'b1;
          end
        end else begin
          cntD = cntQ - CNT_W'(1);
        end
      end
      PH_WAIT: begin
        if (cntZero) begin
          phaseD = PH_IDLE;
          goIdle = 1'b1;
        end else begin
          cntD = cntQ - CNT_W'(1);
        end
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      cntQ   <= '0;
      kindQ  <= KIND_CMD;
      pulseQ <= '0;
      holdQ  <= '0;
      waitQ  <= '0;
      doneQ  <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      cntQ   <= cntD;
      doneQ  <= goIdle;
      if (reqAccept) begin
        kindQ  <= cycKind_t'(reqKind);
        pulseQ <= halfSel[PULSE_LSB +: FIELD_W];
        holdQ  <= halfSel[HOLD_LSB  +: FIELD_W];
        waitQ  <= halfSel[WAIT_LSB  +: FIELD_W];
      end
    end
  end

  assign active = (phaseQ == PH_SETUP) || (phaseQ == PH_PULSE) || (phaseQ == PH_HOLD);

  always_comb begin
    strb.loadData = reqAccept;
    strb.drive    = active && !isRead;
    strb.weLow    = (phaseQ == PH_PULSE) && !isRead;
    strb.reLow    = (phaseQ == PH_PULSE) && isRead;
    strb.capture  = (phaseQ == PH_PULSE) && isRead && cntZero;
    strb.cleOn    = active && (kindQ == KIND_CMD);
    strb.aleOn    = active && (kindQ == KIND_ADDR);
  end

endmodule

// File: rtl/nandStrobeDp.sv
module nandStrobeDp
  import nandStrobePkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] nandDqIn,
  output logic [DATA_W-1:0] rdData,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [DATA_W-1:0] nandDq,
  output logic              nandDqOe
);

  logic [DATA_W-1:0] outByteQ;
  logic [DATA_W-1:0] inByteQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outByteQ <= '0;
      inByteQ  <= '0;
    end else begin
      if (strb.loadData) outByteQ <= reqData;
      if (strb.capture)  inByteQ  <= nandDqIn;
    end
  end

  assign rdData   = inByteQ;
  assign nandDq   = outByteQ;
  assign nandDqOe = strb.drive;
  assign nandWeN  = !strb.weLow;
  assign nandReN  = !strb.reLow;
  assign nandCle  = strb.cleOn;
  assign nandAle  = strb.aleOn;

endmodule

// File: rtl/nandStrobeGen.sv
module nandStrobeGen
  import nandStrobePkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int DATA_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [1:0]           reqKind,
  input  logic [DATA_W-1:0]    reqData,
  input  logic [8*FIELD_W-1:0] timingWord,
  output logic                 reqAccept,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_W-1:0]    rdData,
  input  logic [DATA_W-1:0]    nandDqIn,
  output logic                 nandCle,
  output logic                 nandAle,
  output logic                 nandWeN,
  output logic                 nandReN,
  output logic [DATA_W-1:0]    nandDq,
  output logic                 nandDqOe
);

  strobe_t strb;

  nandStrobeCtl #(.FIELD_W(FIELD_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .timingWord (timingWord),
    .reqAccept  (reqAccept),
    .busy       (busy),
    .done       (done),
    .strb       (strb)
  );

  nandStrobeDp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqData  (reqData),
    .nandDqIn (nandDqIn),
    .rdData   (rdData),
    .nandCle  (nandCle),
    .nandAle  (nandAle),
    .nandWeN  (nandWeN),
    .nandReN  (nandReN),
    .nandDq   (nandDq),
    .nandDqOe (nandDqOe)
  );

endmodule

// File: rtl/nandStrobeChk.sv
module nandStrobeChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqAccept,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rdData,
  input logic              nandCle,
  input logic              nandAle,
  input logic              nandWeN,
  input logic              nandReN,
  input logic              nandDqOe
);

  p_latch_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  p_read_no_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandDqOe);

  p_rd_update_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> $past(!nandReN));

  p_we_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> nandDqOe);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (nandWeN && nandReN && !nandCle && !nandAle && !nandDqOe));

  p_accept_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |-> (reqValid && !busy));

  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |=> busy);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $fell(busy));

endmodule

bind nandStrobeGen nandStrobeChk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqAccept (reqAccept),
  .busy      (busy),
  .done      (done),
  .rdData    (rdData),
  .nandCle   (nandCle),
  .nandAle   (nandAle),
  .nandWeN   (nandWeN),
  .nandReN   (nandReN),
  .nandDqOe  (nandDqOe)
);

// File: tb/nandStrobeGen_tb.sv
`timescale 1ns/1ps
module nandStrobeGen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [7:0]  reqData = 8'h00;
  logic [31:0] timingWord = 32'h0;
  logic        reqAccept, busy, done;
  logic [7:0]  rdData;
  logic [7:0]  nandDqIn;
  logic        nandCle, nandAle, nandWeN, nandReN, nandDqOe;
  logic [7:0]  nandDq;

  always #4 clk = ~clk;

  nandStrobeGen u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqData(reqData), .timingWord(timingWord), .reqAccept(reqAccept),
    .busy(busy), .done(done), .rdData(rdData), .nandDqIn(nandDqIn),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandDq(nandDq), .nandDqOe(nandDqOe)
  );

  typedef struct {
    logic       cle, ale, weN, reN, oe, bsy, dn, acc;
    logic [7:0] dq, rd, dqIn;
    string      tag;
  } item_t;

  item_t expQ[$];
  int    nChecks = 0;
  int    nFails  = 0;
  logic  [7:0] lastRd = 8'h00;
  bit    finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare every clock against the expected trace
  always @(negedge clk) begin
    if (!rstN) begin
      nandDqIn = 8'h00;
    end else if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      nandDqIn = it.dqIn;
      chk(nandCle == it.cle, it.tag, "cle", 32'(nandCle), 32'(it.cle));
      chk(nandAle == it.ale, it.tag, "ale", 32'(nandAle), 32'(it.ale));
      chk(nandWeN == it.weN, it.tag, "weN", 32'(nandWeN), 32'(it.weN));
      chk(nandReN == it.reN, it.tag, "reN", 32'(nandReN), 32'(it.reN));
      chk(nandDqOe == it.oe, it.tag, "oe", 32'(nandDqOe), 32'(it.oe));
      if (it.oe) chk(nandDq == it.dq, it.tag, "dq", 32'(nandDq), 32'(it.dq));
      chk(busy == it.bsy, it.tag, "busy", 32'(busy), 32'(it.bsy));
      chk(done == it.dn, it.tag, "done", 32'(done), 32'(it.dn));
      chk(rdData == it.rd, it.tag, "rdData", 32'(rdData), 32'(it.rd));
      chk(reqAccept == it.acc, it.tag, "accept", 32'(reqAccept), 32'(it.acc));
    end
  end

  function automatic item_t mk(input logic cle, ale, weN, reN, oe, bsy, dn,
                               input logic [7:0] dq, rd, dqIn, input string tag);
    item_t it;
    it.cle = cle; it.ale = ale; it.weN = weN; it.reN = reN; it.oe = oe;
    it.bsy = bsy; it.dn = dn; it.acc = 1'b0;
    it.dq = dq; it.rd = rd; it.dqIn = dqIn; it.tag = tag;
    return it;
  endfunction

  // Driver: offer a request, build its expected trace (R1..R9)
  task automatic runReq(input logic [1:0] kind, input logic [7:0] data,
                        input logic [31:0] tw, input logic [7:0] rdVal,
                        input bit keepValid);
    logic [15:0] half;
    int s, p, h, w, total;
    logic isRd, cle, ale;
    logic [7:0] rdAfter;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b1; reqKind = kind; reqData = data; timingWord = tw;
    #1 chk(reqAccept == 1'b1, "R7", "accept when idle", 32'(reqAccept), 32'd1);
    // R1: write-type half is [31:16], read half is [15:0]
    isRd = (kind == 2'd3);
    half = isRd ? tw[15:0] : tw[31:16];
    s = int'(half[3:0]); h = int'(half[7:4]); p = int'(half[11:8]); w = int'(half[15:12]);
    cle = (kind == 2'd0);
    ale = (kind == 2'd1);
    rdAfter = isRd ? rdVal : lastRd;
    total = 0;
    @(posedge clk);
    #1;
    for (int i = 0; i <= s; i++) begin
      expQ.push_back(mk(cle, ale, 1'b1, 1'b1, !isRd, 1'b1, 1'b0, data, lastRd, ~rdVal, "R2"));
      total++;
    end
    for (int i = 0; i <= p; i++) begin
      expQ.push_back(mk(cle, ale, isRd, !isRd, !isRd, 1'b1, 1'b0, data, lastRd,
                        (i == p) ? rdVal : ~rdVal, isRd ? "R6" : "R5"));
      total++;
    end
    for (int i = 0; i <= h; i++) begin
      expQ.push_back(mk(cle, ale, 1'b1, 1'b1, !isRd, 1'b1, 1'b0, data, rdAfter, ~rdVal, "R4"));
      total++;
    end
    for (int i = 0; i < 2 * w; i++) begin
      expQ.push_back(mk(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, data, rdAfter, ~rdVal, "R3"));
      total++;
    end
    expQ.push_back(mk(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, data, rdAfter, ~rdVal, "R8"));
    total++;
    lastRd = rdAfter;
    // R9: rewrite the timing word mid-cycle
    timingWord = ~tw;
    if (keepValid) begin
      // R7: a competing request while busy is ignored
      reqKind = ~kind;
      reqData = ~data;
      repeat (total - 1) @(posedge clk);
      #1 reqValid = 1'b0;
    end else begin
      reqValid = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 1'b0 && done == 1'b0, "R10", "busy/done in reset", {30'd0, busy, done}, 32'd0);
    chk(nandWeN && nandReN, "R10", "strobes in reset", {30'd0, nandWeN, nandReN}, 32'd3);
    chk(!nandCle && !nandAle && !nandDqOe, "R10", "latch/oe in reset",
        {29'd0, nandCle, nandAle, nandDqOe}, 32'd0);
    chk(rdData == 8'h00, "R10", "rdData in reset", 32'(rdData), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && nandWeN && nandReN, "R10", "idle after reset",
        {29'd0, busy, nandWeN, nandReN}, 32'd3);

    runReq(2'd0, 8'h70, 32'h0000_0000, 8'h11, 1'b0);   // R2 all-zero timing, command
    runReq(2'd1, 8'h5A, 32'h2310_5A5A, 8'h22, 1'b0);   // R1 address, distinct halves
    runReq(2'd2, 8'hA5, 32'h1F42_7777, 8'h33, 1'b0);   // R5 write data, long pulse
    runReq(2'd3, 8'h00, 32'h9999_3215, 8'hC3, 1'b0);   // R6 read, exact sample clock
    runReq(2'd2, 8'h3C, 32'hF000_0000, 8'h44, 1'b1);   // R3 long wait, R7 competing request
    runReq(2'd3, 8'hFF, 32'hFFFF_0000, 8'h96, 1'b1);   // R6 zero read timing, R9
    runReq(2'd0, 8'h90, 32'h0F0F_F0F0, 8'h55, 1'b0);   // R4 command, rdData holds
    runReq(2'd3, 8'h00, 32'h0000_FFFF, 8'h69, 1'b0);   // R2 max read phases
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R8", "quiet after last", {30'd0, busy, done}, 32'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule